// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block merges up to 32 interrupt lines into a single request line for a processor. Each line is watched for a rising edge; an edge latches a pending bit that stays set until software acknowledges it. A per-line enable mask selects which pending bits may reach the processor. A two-bit master switch gates the request output, and a vector register reports the number of the lowest-numbered line that is both pending and enabled.

Software reaches the block through a small request/response port of 32-bit whole-word accesses. `req_ready` is tied high, so a request is taken on every clock edge where `req_valid` is high. A read returns its data with `rsp_valid` exactly one cycle after acceptance, and the response cannot be stalled. A write produces no response. The port selects a register by word index, which is the byte offset divided by four.

Top module: `irqc_top`

## Requirements
- R1: After reset the status, enable and master registers read 0, the vector register reads 0xFFFFFFFF, and `irq_out` is low.
- R2: A rising edge on `irq_lines[n]` sets pending bit n in the status register (word 0), and the pending bit is set at the clock edge where the new level is first seen.
- R3: A pending bit stays set after its input falls. An input held high does not set the bit again once it has been acknowledged.
- R4: A write to the acknowledge register (word 3) clears every pending bit whose written bit is 1 and leaves the others. Writing 0xFFFFFFFF clears all pending bits.
- R5: If a rising edge and an acknowledge of the same bit take effect at the same clock edge, the pending bit stays set.
- R6: A write to the enable register (word 2) replaces the whole mask, and the new mask reads back. Writing 0 disables every line.
- R7: A write to set-enable (word 4) ORs its bits into the mask. A write to clear-enable (word 5) clears its bits in the mask. The write-only words 3, 4 and 5 read 0.
- R8: Word 1 reads the bitwise AND of the pending bits and the enable mask.
- R9: The vector register (word 6) reads the index of the lowest-numbered pending enabled line, zero-extended. When no line is both pending and enabled, it reads 0xFFFFFFFF.
- R10: The master register (word 7) holds two bits, and bits 31:2 read 0. `irq_out` is high one cycle after both master bits are 1 and at least one line is pending and enabled, and it is low otherwise.
- R11: `req_ready` is always high. Every accepted read gives exactly one `rsp_valid` pulse in the next cycle. A write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Interrupt inputs, synchronous to clk |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_word | input | 3 | Register word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
Assertions check the following on every cycle: pending bits never drop without an acknowledge, and a detected edge always lands in the pending set. They also check that set-enable and clear-enable writes reach the mask, that the vector names the lowest active line or reads all ones, that the request never rises without both master bits, and that each response matches a read. The bench scenarios cover the rest. These are the exact read-back values, the edge-versus-acknowledge collision, the fact that a held level does not re-trigger after an acknowledge, the top and bottom line numbers, and the timing of the request as the master bits and the mask change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_ACTIVE = 3'd1,
    REG_ENABLE = 3'd2,
    REG_ACK    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_VECTOR = 3'd6,
    REG_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] ack_mask,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise_w;

  assign rise_w = lines & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lines;
      // a new edge overrides a simultaneous acknowledge
      pend_q <= (pend_q & ~ack_mask) | rise_w;
    end
  end

  assign pend = pend_q;

  // R3: a pending bit only drops when acknowledged
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(ack_mask) & ~pend_q) == '0));

  // R2 / R5: every detected edge is pending afterwards
  assert_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise_w) & ~pend_q) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N      = 32,
  parameter int DATA_W = 32
) (
  input  logic [N-1:0]      active,
  output logic              found,
  output logic [DATA_W-1:0] vector
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) idx = IDX_W'(i);
    end
  end

  assign found  = |active;
  assign vector = found ? {{(DATA_W-IDX_W){1'b0}}, idx} : '1;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N      = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_word,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [N-1:0]      pend,
  input  logic [N-1:0]      active,
  input  logic [DATA_W-1:0] vector,
  output logic [N-1:0]      en,
  output logic              master_on,
  output logic [N-1:0]      ack_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  reg_sel_e          sel;
  logic              wr, rd;
  logic [N-1:0]      en_q;
  logic [1:0]        mer_q;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  assign sel = reg_sel_e'(req_word);
  assign wr  = req_valid && req_write;
  assign rd  = req_valid && !req_write;

  assign ack_mask = (wr && sel == REG_ACK) ? req_wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      mer_q <= '0;
    end else if (wr) begin
      case (sel)
        REG_ENABLE: en_q  <= req_wdata[N-1:0];
        REG_SETEN:  en_q  <= en_q | req_wdata[N-1:0];
        REG_CLREN:  en_q  <= en_q & ~req_wdata[N-1:0];
        REG_MASTER: mer_q <= req_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      REG_STATUS: rdata_d = DATA_W'(pend);
      REG_ACTIVE: rdata_d = DATA_W'(active);
      REG_ENABLE: rdata_d = DATA_W'(en_q);
      REG_VECTOR: rdata_d = vector;
      REG_MASTER: rdata_d = DATA_W'(mer_q);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign en        = en_q;
  assign master_on = &mer_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  assert_seten_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_SETEN) |=> ((en_q & $past(req_wdata[N-1:0])) == $past(req_wdata[N-1:0])));

  assert_clren_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_CLREN) |=> ((en_q & $past(req_wdata[N-1:0])) == '0));

  assert_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N      = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_lines,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      pend, en, active, ack_mask;
  logic              master_on, found;
  logic [DATA_W-1:0] vector;
  logic              irq_q;

  assign req_ready = 1'b1;
  assign active    = pend & en;

  irqc_capture #(.N(N)) u_capture (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines),
    .ack_mask(ack_mask), .pend(pend)
  );

  irqc_prio #(.N(N), .DATA_W(DATA_W)) u_prio (
    .active(active), .found(found), .vector(vector)
  );

  irqc_regs #(.N(N), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_wdata(req_wdata), .pend(pend), .active(active),
    .vector(vector), .en(en), .master_on(master_on), .ack_mask(ack_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= master_on && found;
  end

  assign irq_out = irq_q;

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($past(master_on) && ($past(pend) & $past(en)) != '0));

  assert_vec_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0) |-> (active[vector[IDX_W-1:0]] &&
      ((active & ((N'(1) << vector[IDX_W-1:0]) - N'(1))) == '0)));

  assert_vec_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (vector == '1));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_word = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_word(req_word),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out)
  );

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          fails++;
          $display("FAIL %s: read act=%h exp=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic check_bit(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%b exp=%b", t, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] w, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [2:0] w, logic [31:0] e, string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = w;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk);
    irq_lines = irq_lines | m;
    @(negedge clk);
    irq_lines = irq_lines & ~m;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check_bit("R1 irq_out", irq_out, 1'b0);
    check_bit("R11 ready", req_ready, 1'b1);
    rd(3'd0, 32'h0, "R1 status");
    rd(3'd2, 32'h0, "R1 enable");
    rd(3'd7, 32'h0, "R1 master");
    rd(3'd6, 32'hFFFF_FFFF, "R1 vector");

    // R6 whole-mask write, R10 master on
    wr(3'd2, 32'h0000_0030);
    rd(3'd2, 32'h0000_0030, "R6 enable readback");
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, 32'h3, "R10 master upper bits read 0");

    // R2/R3 edge capture, held after fall
    pulse(32'h0000_0031);
    idle(2);
    rd(3'd0, 32'h0000_0031, "R3 status after fall");
    rd(3'd1, 32'h0000_0030, "R8 active");
    rd(3'd6, 32'h4, "R9 vector lowest");
    check_bit("R10 irq asserted", irq_out, 1'b1);

    // R10 one master bit is not enough
    wr(3'd7, 32'h1);
    idle(2);
    check_bit("R10 irq gated", irq_out, 1'b0);
    wr(3'd7, 32'h3);
    idle(2);
    check_bit("R10 irq back", irq_out, 1'b1);

    // R7 set/clear enable
    wr(3'd4, 32'h1);
    rd(3'd2, 32'h0000_0031, "R7 set-enable");
    rd(3'd6, 32'h0, "R9 vector bit0");
    wr(3'd5, 32'h20);
    rd(3'd2, 32'h0000_0011, "R7 clear-enable");
    rd(3'd3, 32'h0, "R7 ack reads 0");
    rd(3'd4, 32'h0, "R7 seten reads 0");
    rd(3'd5, 32'h0, "R7 clren reads 0");

    // R4 acknowledge
    wr(3'd3, 32'h1);
    rd(3'd0, 32'h0000_0030, "R4 ack one bit");
    rd(3'd6, 32'h4, "R4 vector after ack");
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R4 ack all");
    rd(3'd6, 32'hFFFF_FFFF, "R9 none pending");
    idle(1);
    check_bit("R10 irq low after ack", irq_out, 1'b0);

    // R3 held level does not retrigger after ack
    @(negedge clk);
    irq_lines[7] = 1'b1;
    idle(2);
    wr(3'd3, 32'h80);
    idle(2);
    rd(3'd0, 32'h0, "R3 held level no retrigger");
    @(negedge clk);
    irq_lines[7] = 1'b0;

    // R5 edge and ack at the same edge
    pulse(32'h4);
    idle(1);
    @(negedge clk);
    irq_lines[2] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_word = 3'd3; req_wdata = 32'h4;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    irq_lines[2] = 1'b0;
    rd(3'd0, 32'h4, "R5 edge wins");
    wr(3'd3, 32'hFFFF_FFFF);

    // R9 top line, R6 disable all
    wr(3'd2, 32'hFFFF_FFFF);
    pulse(32'h8000_0000);
    idle(1);
    rd(3'd6, 32'd31, "R9 vector top line");
    wr(3'd2, 32'h0);
    idle(2);
    check_bit("R6 irq low when all disabled", irq_out, 1'b0);
    rd(3'd6, 32'hFFFF_FFFF, "R6 vector none enabled");
    rd(3'd0, 32'h8000_0000, "R6 pending kept while disabled");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11: missing responses act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule